// File: doc/BRIEF.md
# Thresholded Multi-Channel Hit Summarizer

This block reduces one board's worth of readout to a trigger word. Every output interval of 12 clock cycles it adds up to three ADC charge samples per channel, notes whether the channel's time-to-digital converter flagged a hit in that interval, and quantises the sum against two run-time thresholds into a 2-bit class. The 48 classes leave the block together as one 96-bit word, qualified by a one-cycle valid pulse.

A common strobe marks each new sample on all channels at once. The hit flag decides whether a channel's sum counts as signal charge or as baseline. A channel with no hit always reports class 0, whatever its sum. The two thresholds are written through a small write port. A written value is staged and only becomes active at a window boundary, so no window is classified against a mix of old and new limits.

Top module: `hit_summarizer`

## Requirements
- R1: Each channel's window value is the unsigned sum of the first three sample strobes of the window. The sum is held at sample width plus 2 bits, so three full-scale 12-bit samples (sum 12285) classify without wrap-around.
- R2: A channel reports code 0 unless its hit input was high in at least one cycle of the window, the window's last cycle included. The hit record clears at each window boundary and never carries into the next window.
- R3: A channel with a hit reports code 3 when sum >= upper threshold. Otherwise it reports code 1 when sum < lower threshold and code 2 when sum >= lower threshold. The upper comparison wins when the two thresholds overlap.
- R4: Channel n's code occupies bits [2n+1:2n] of the output word, with channel 0 at bits [1:0].
- R5: Windows are 12 cycles long and run back to back from the first clock edge after reset is released. The valid output is high for exactly one cycle, the cycle after each window's last cycle, so pulses are 12 cycles apart.
- R6: The output word changes only together with a valid pulse and holds its value between pulses.
- R7: A write with select 0 stages the lower threshold and a write with select 1 stages the upper threshold. A write in any cycle of a window except its last is used from the following window on. The window that contains the write is still classified with the previous limits.
- R8: Sample strobes after the third in a window are ignored.
- R9: During reset the valid output and the word are 0. The thresholds come out of reset at 3000 (lower) and 8000 (upper). The first valid pulse follows 12 cycles after reset release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleValid | input | 1 | New ADC sample on all channels this cycle |
| sampleData | input | 576 | 48 samples of 12 bits, channel n at bits [12n+11:12n] |
| hitIn | input | 48 | Per-channel hit flag |
| cfgWrEn | input | 1 | Threshold write strobe |
| cfgSel | input | 1 | 0 selects lower threshold, 1 selects upper threshold |
| cfgWrData | input | 14 | Threshold value |
| wordValid | output | 1 | One-cycle pulse marking a new trigger word |
| wordOut | output | 96 | Packed 2-bit channel codes |

## Verification
Each window's word is due one cycle after the window's last cycle. The stimulus task therefore synchronises on a valid pulse, drives 12 cycles on falling edges, and queues its expected word. A monitor samples on the falling edge and pops that entry at the very next pulse. Threshold writes have their effect two steps later: the bench model moves staged limits into the active set only after the expected word of the writing window has been computed. The monitor also measures 12 cycles between pulses and checks that the word holds still in every cycle between them.

// File: rtl/hitsum_pkg.sv
package hitsum_pkg;

  typedef struct packed {
    logic accEn;     // add the current sample to the running sums
    logic winClose;  // last cycle of the window: classify and restart
  } hs_strobe_t;

  typedef enum logic [1:0] {
    CODE_NONE = 2'd0,
    CODE_LOW  = 2'd1,
    CODE_MID  = 2'd2,
    CODE_HIGH = 2'd3
  } hs_code_e;

endpackage

// File: rtl/hitsum_ctrl.sv
module hitsum_ctrl
  import hitsum_pkg::*;
#(
  parameter int WIN_CYCLES      = 12,
  parameter int SAMPLES_PER_WIN = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sampleValid,
  output hs_strobe_t strobe
);
  localparam int CNT_W  = $clog2(WIN_CYCLES);
  localparam int SCNT_W = $clog2(SAMPLES_PER_WIN + 1);

  logic [CNT_W-1:0]  cycCnt;
  logic [SCNT_W-1:0] sampCnt;
  logic              lastCycle;
  logic              takeSample;

  assign lastCycle  = (cycCnt == CNT_W'(WIN_CYCLES - 1));
  assign takeSample = sampleValid && (sampCnt < SCNT_W'(SAMPLES_PER_WIN));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cycCnt  <= '0;
      sampCnt <= '0;
    end else begin
      cycCnt <= lastCycle ? '0 : cycCnt + 1'b1;
      if (lastCycle)       sampCnt <= '0;
      else if (takeSample) sampCnt <= sampCnt + 1'b1;
    end
  end

  always_comb begin
    strobe.accEn    = takeSample;
    strobe.winClose = lastCycle;
  end

endmodule

// File: rtl/hitsum_thresh.sv
module hitsum_thresh #(
  parameter int SUM_W  = 14,
  parameter int LO_RST = 3000,
  parameter int UP_RST = 8000
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWrEn,
  input  logic             cfgSel,
  input  logic [SUM_W-1:0] cfgWrData,
  input  logic             thrLoad,
  output logic [SUM_W-1:0] actLo,
  output logic [SUM_W-1:0] actUp
);
  logic [SUM_W-1:0] pendLo;
  logic [SUM_W-1:0] pendUp;

  // staged copy, written any time
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendLo <= SUM_W'(LO_RST);
      pendUp <= SUM_W'(UP_RST);
    end else if (cfgWrEn) begin
      if (cfgSel) pendUp <= cfgWrData;
      else        pendLo <= cfgWrData;
    end
  end

  // active copy, moves only at a window boundary
  always_ff @(posedge clk) begin
    if (!rstN) begin
      actLo <= SUM_W'(LO_RST);
      actUp <= SUM_W'(UP_RST);
    end else if (thrLoad) begin
      actLo <= pendLo;
      actUp <= pendUp;
    end
  end

endmodule

// File: rtl/hitsum_lanes.sv
module hitsum_lanes
  import hitsum_pkg::*;
#(
  parameter int NUM_CH   = 48,
  parameter int SAMPLE_W = 12,
  parameter int SUM_W    = 14
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  hs_strobe_t                 strobe,
  input  logic [NUM_CH*SAMPLE_W-1:0] sampleData,
  input  logic [NUM_CH-1:0]          hitIn,
  input  logic [SUM_W-1:0]           actLo,
  input  logic [SUM_W-1:0]           actUp,
  output logic [2*NUM_CH-1:0]        wordOut,
  output logic                       wordValid
);

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_lane
    logic [SUM_W-1:0] acc;
    logic [SUM_W-1:0] sumNow;
    logic             hitLat;
    logic             hitNow;
    hs_code_e         codeNext;
    hs_code_e         codeQ;

    assign sumNow = acc + (strobe.accEn ? SUM_W'(sampleData[ch*SAMPLE_W +: SAMPLE_W]) : '0);
    assign hitNow = hitLat | hitIn[ch];

    always_comb begin
      if (!hitNow)             codeNext = CODE_NONE;
      else if (sumNow >= actUp) codeNext = CODE_HIGH;
      else if (sumNow < actLo)  codeNext = CODE_LOW;
      else                      codeNext = CODE_MID;
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        acc    <= '0;
        hitLat <= 1'b0;
        codeQ  <= CODE_NONE;
      end else if (strobe.winClose) begin
        acc    <= '0;
        hitLat <= 1'b0;
        codeQ  <= codeNext;
      end else begin
        acc    <= sumNow;
        hitLat <= hitNow;
      end
    end

    assign wordOut[2*ch +: 2] = codeQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) wordValid <= 1'b0;
    else       wordValid <= strobe.winClose;
  end

endmodule

// File: rtl/hit_summarizer.sv
module hit_summarizer
  import hitsum_pkg::*;
#(
  parameter int NUM_CH          = 48,
  parameter int SAMPLE_W        = 12,
  parameter int SAMPLES_PER_WIN = 3,
  parameter int WIN_CYCLES      = 12,
  parameter int LO_RST          = 3000,
  parameter int UP_RST          = 8000,
  localparam int SUM_W          = SAMPLE_W + $clog2(SAMPLES_PER_WIN + 1)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       sampleValid,
  input  logic [NUM_CH*SAMPLE_W-1:0] sampleData,
  input  logic [NUM_CH-1:0]          hitIn,
  input  logic                       cfgWrEn,
  input  logic                       cfgSel,
  input  logic [SUM_W-1:0]           cfgWrData,
  output logic                       wordValid,
  output logic [2*NUM_CH-1:0]        wordOut
);
  hs_strobe_t       strobe;
  logic [SUM_W-1:0] actLo;
  logic [SUM_W-1:0] actUp;

  hitsum_ctrl #(
    .WIN_CYCLES(WIN_CYCLES),
    .SAMPLES_PER_WIN(SAMPLES_PER_WIN)
  ) u_ctrl (
    .clk(clk),
    .rstN(rstN),
    .sampleValid(sampleValid),
    .strobe(strobe)
  );

  hitsum_thresh #(
    .SUM_W(SUM_W),
    .LO_RST(LO_RST),
    .UP_RST(UP_RST)
  ) u_thresh (
    .clk(clk),
    .rstN(rstN),
    .cfgWrEn(cfgWrEn),
    .cfgSel(cfgSel),
    .cfgWrData(cfgWrData),
    .thrLoad(strobe.winClose),
    .actLo(actLo),
    .actUp(actUp)
  );

  hitsum_lanes #(
    .NUM_CH(NUM_CH),
    .SAMPLE_W(SAMPLE_W),
    .SUM_W(SUM_W)
  ) u_lanes (
    .clk(clk),
    .rstN(rstN),
    .strobe(strobe),
    .sampleData(sampleData),
    .hitIn(hitIn),
    .actLo(actLo),
    .actUp(actUp),
    .wordOut(wordOut),
    .wordValid(wordValid)
  );

endmodule

// File: rtl/hit_summarizer_chk.sv
module hit_summarizer_chk #(
  parameter int NUM_CH     = 48,
  parameter int SUM_W      = 14,
  parameter int WIN_CYCLES = 12
) (
  input logic                clk,
  input logic                rstN,
  input logic [NUM_CH-1:0]   hitIn,
  input logic                wordValid,
  input logic [2*NUM_CH-1:0] wordOut,
  input logic                winClose,
  input logic [SUM_W-1:0]    actLo,
  input logic [SUM_W-1:0]    actUp
);
  int   gapCnt;
  logic hitAcc;
  logic prevHit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      gapCnt  <= 0;
      hitAcc  <= 1'b0;
      prevHit <= 1'b0;
    end else begin
      gapCnt <= wordValid ? 1 : gapCnt + 1;
      if (winClose) begin
        hitAcc  <= 1'b0;
        prevHit <= hitAcc | (|hitIn);
      end else begin
        hitAcc  <= hitAcc | (|hitIn);
      end
    end
  end

  // R5
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    wordValid |=> !wordValid);

  // R5
  valid_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    wordValid |-> gapCnt == WIN_CYCLES);

  // R6
  word_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !wordValid |-> $stable(wordOut));

  // R2
  no_hit_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wordValid && !prevHit) |-> (wordOut == '0));

  // R7
  thresh_boundary_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(winClose) |-> ($stable(actLo) && $stable(actUp)));

endmodule

bind hit_summarizer hit_summarizer_chk #(
  .NUM_CH(NUM_CH),
  .SUM_W(SUM_W),
  .WIN_CYCLES(WIN_CYCLES)
) chk_i (
  .clk(clk),
  .rstN(rstN),
  .hitIn(hitIn),
  .wordValid(wordValid),
  .wordOut(wordOut),
  .winClose(strobe.winClose),
  .actLo(actLo),
  .actUp(actUp)
);

// File: tb/hit_summarizer_tb_top.sv
module hit_summarizer_tb_top;
  localparam int NCH  = 48;
  localparam int SW   = 12;
  localparam int SUMW = 14;
  localparam int WIN  = 12;

  logic              clk = 1'b0;
  logic              rstN;
  logic              sampleValid;
  logic [NCH*SW-1:0] sampleData;
  logic [NCH-1:0]    hitIn;
  logic              cfgWrEn;
  logic              cfgSel;
  logic [SUMW-1:0]   cfgWrData;
  logic              wordValid;
  logic [2*NCH-1:0]  wordOut;

  always #4 clk = ~clk;

  hit_summarizer dut_i (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .sampleData(sampleData),
    .hitIn(hitIn), .cfgWrEn(cfgWrEn), .cfgSel(cfgSel), .cfgWrData(cfgWrData),
    .wordValid(wordValid), .wordOut(wordOut)
  );

  typedef struct {
    logic [2*NCH-1:0] word;
    string            tag;
  } exp_t;

  exp_t expQ[$];
  int   checks = 0;
  int   errors = 0;
  bit   done   = 1'b0;
  int   pendLo = 3000, pendUp = 8000, curLo = 3000, curUp = 8000;

  function automatic int sampVal(int mode, int seed, int cval, int ch, int k);
    if (mode == 1) return cval;
    return (ch * 293 + k * 577 + seed * 1031 + ch * k * 17) % 4096;
  endfunction

  task automatic checkWord(string tag, logic [2*NCH-1:0] act, logic [2*NCH-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic checkInt(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic zeroInputs();
    sampleValid = 1'b0;
    sampleData  = '0;
    hitIn       = '0;
    cfgWrEn     = 1'b0;
    cfgSel      = 1'b0;
    cfgWrData   = '0;
  endtask

  // Driver: one full window aligned to a valid pulse, expected word queued.
  task automatic runWindow(int mode, int seed, int cval, logic [NCH-1:0] hitMask, int hitCyc,
                           logic [WIN-1:0] vMask, int cfgCyc, int newLo, int newUp, string tag);
    int   sums[NCH];
    int   k = 0;
    exp_t e;
    do @(negedge clk); while (!wordValid);
    for (int ch = 0; ch < NCH; ch++) sums[ch] = 0;
    for (int cyc = 0; cyc < WIN; cyc++) begin
      if (cyc > 0) @(negedge clk);
      zeroInputs();
      sampleValid = vMask[cyc];
      if (cyc == hitCyc) hitIn = hitMask;
      if (vMask[cyc]) begin
        for (int ch = 0; ch < NCH; ch++) begin
          sampleData[ch*SW +: SW] = SW'(sampVal(mode, seed, cval, ch, k));
          if (k < 3) sums[ch] += sampVal(mode, seed, cval, ch, k);
        end
        k++;
      end
      if (cfgCyc >= 0 && cyc == cfgCyc) begin
        cfgWrEn = 1'b1; cfgSel = 1'b0; cfgWrData = SUMW'(newLo); pendLo = newLo;
      end
      if (cfgCyc >= 0 && cyc == cfgCyc + 1) begin
        cfgWrEn = 1'b1; cfgSel = 1'b1; cfgWrData = SUMW'(newUp); pendUp = newUp;
      end
    end
    for (int ch = 0; ch < NCH; ch++) begin
      int code;
      if (!hitMask[ch])         code = 0;
      else if (sums[ch] >= curUp) code = 3;
      else if (sums[ch] < curLo)  code = 1;
      else                        code = 2;
      e.word[2*ch +: 2] = 2'(code);
    end
    e.tag = tag;
    expQ.push_back(e);
    curLo = pendLo;
    curUp = pendUp;
  endtask

  // Monitor: compares each word at its pulse, timing and hold in between.
  initial begin
    int               since = 0;
    bit               seen  = 1'b0;
    logic [2*NCH-1:0] last  = '0;
    exp_t             e;
    wait (rstN === 1'b1);
    forever begin
      @(negedge clk);
      since++;
      if (wordValid) begin
        if (seen) checkInt("R5 pulse spacing", since, WIN);
        since = 0;
        seen  = 1'b1;
        if (expQ.size() > 0) e = expQ.pop_front();
        else begin
          e.word = '0;
          e.tag  = "R2 idle window";
        end
        checkWord(e.tag, wordOut, e.word);
        last = wordOut;
      end else begin
        checkWord("R6 word held between pulses", wordOut, last);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R5 watchdog: actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int n = 0;
    rstN = 1'b0;
    zeroInputs();
    repeat (5) @(negedge clk);
    checkInt("R9 valid low in reset", int'(wordValid), 0);
    checkWord("R9 word zero in reset", wordOut, '0);
    rstN = 1'b1;
    do begin @(negedge clk); n++; end while (!wordValid && n < 100);
    checkInt("R9 first pulse after release", n, WIN);

    runWindow(0, 1, 0, '1, 2, 12'h222, -1, 0, 0, "R1 R3 R4 random sums all hit");
    runWindow(0, 2, 0, 48'hAAAA_AAAA_AAAA, 11, 12'h811, -1, 0, 0, "R2 hit in last cycle");
    runWindow(0, 3, 0, '0, 0, 12'h00E, -1, 0, 0, "R2 no hit, latch cleared");
    runWindow(1, 0, 1000, '1, 6, 12'h148, 5, 100, 3000, "R3 R7 sum at lower, old limits");
    runWindow(1, 0, 1000, '1, 4, 12'h124, 3, 3000, 9000, "R3 R7 sum at upper, new limits");
    runWindow(1, 0, 999, '1, 0, 12'h421, 7, 12000, 12285, "R3 sum below lower");
    runWindow(1, 0, 4095, '1, 9, 12'h061, 2, 3000, 8000, "R1 full-scale sum");
    runWindow(0, 8, 0, '1, 3, 12'h00F, -1, 0, 0, "R8 fourth strobe ignored");
    runWindow(0, 9, 0, 48'h0000_FFFF_0F0F, 0, 12'h124, -1, 0, 0, "R2 R4 partial hits");
    @(negedge clk);
    zeroInputs();
    repeat (3 * WIN) @(negedge clk);
    checkInt("R5 every window produced a word", expQ.size(), 0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule